// File: doc/BRIEF.md
# Cross-Side Doorbell Interrupt Controller

This block connects two processing sides, A and B, through a set of doorbells. Each side owns a small register port with two registers: a control register, through which it rings doorbells toward the peer, sends a non-maskable interrupt, announces a mailbox reset and sets its own interrupt enables; and a status register, where it sees the doorbells, the NMI and the reset notice that the peer raised toward it. Each side gets an interrupt output and an NMI output.

A doorbell request stays visible to its sender until the receiver acknowledges it by writing 1 to the matching pending bit. The sender can therefore read its own control register and decline to ring a doorbell whose previous ring has not been consumed. Zeros written to the request, NMI and reset-announce bits are ignored, so a read-modify-write of the control register never cancels or re-fires a request. A reset notice, when the receiver has enabled it, is folded into the receiver's doorbell interrupt.

The number of doorbells and the data width are parameters (defaults 4 and 16). All register reads are registered and return the register contents from before any write at the same edge.

Top module: `dbl_xside`

## Requirements
- R1: After a synchronous active-high reset every pending bit, enable, request readback, read data, interrupt output and NMI output is 0.
- R2: A side that writes its control register with bit N-1-n set (N doorbells; doorbell 0 at bit N-1) sets the peer's pending bit for doorbell n, which the peer reads at status bit N-1-n; a 0 in that position has no effect.
- R3: Control bit N-1-n reads 1 while the peer's pending bit for doorbell n is set and reads 0 from the edge at which the peer clears it.
- R4: Status pending bits are cleared by writing 1 to them (doorbell n at bit N-1-n); writing 0 leaves them unchanged.
- R5: Ringing a doorbell whose pending bit is already set has no effect; if the peer clears that bit at the same edge it ends cleared, while a ring toward a clear bit at the same edge as a clear attempt leaves it set.
- R6: A side's interrupt output equals the OR over doorbells of pending AND enable (enable for doorbell n at control bit 2N-1-n), OR the reset-notice pending bit, and changes at the same edge as the state it depends on.
- R7: Writing 1 to control bit 2N sets the peer's NMI pending bit (status bit N), which drives the peer's NMI output regardless of enables and reads back at the sender's control bit 2N; only a 1 written to status bit N+1 clears it, and a 1 written to status bit N has no effect.
- R8: Writing 1 to control bit 2N+2 sets the peer's reset-notice pending bit (status bit N+2) only when the peer's control bit 2N+1 is 1; that bit is write-1-to-clear and raises the interrupt output even with every doorbell enable at 0.
- R9: Read data is registered: one cycle after a cycle with address 0 (control) or 1 (status), read data shows that register as it was before the edge, with unused bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_wr | input | 1 | Side A write strobe |
| a_addr | input | 1 | Side A register select: 0 control, 1 status |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, registered |
| a_irq | output | 1 | Side A doorbell interrupt |
| a_nmi | output | 1 | Side A non-maskable interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_addr | input | 1 | Side B register select: 0 control, 1 status |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, registered |
| b_irq | output | 1 | Side B doorbell interrupt |
| b_nmi | output | 1 | Side B non-maskable interrupt |

## Verification
The bench targets the edge at which a ring and an acknowledge of the same doorbell collide: a design that let the set win would re-fire a consumed doorbell, and one that let the clear win on an idle bit would lose a fresh ring. It writes zeros into request and NMI positions during enable updates, which a design that treated the request field as plain storage would turn into cancelled requests, and writes 1 to the NMI pending position to catch a design that clears it there instead of through its dedicated clear bit. It also announces a reset with the peer's notice enable off and then on, and checks the notice raises the interrupt with all doorbell enables low, which a design that gated it by doorbell 3's enable would miss.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dbl_pend_bit.sv
module dbl_pend_bit #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] nxt_o
);
  logic [W-1:0] q;

  // a set toward a bit that is already set is ignored, so a clear wins there
  assign nxt_o = (q & ~clr_i) | (set_i & ~q);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt_o;
  end

  assign q_o = q;

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R2
    set_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (set_i[i] && !q_o[i]) |=> q_o[i]);
    // R5
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && q_o[i]) |=> !q_o[i]);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_i[i] && !clr_i[i]) |=> $stable(q_o[i]));
  end
endmodule

// File: rtl/dbl_side.sv
module dbl_side
  import dbl_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  in_ring_i,
  input  logic          in_nmi_i,
  input  logic          in_rstgo_i,
  input  logic [N-1:0]  peer_pend_i,
  input  logic          peer_nmi_i,
  output logic [N-1:0]  out_ring_o,
  output logic          out_nmi_o,
  output logic          out_rstgo_o,
  output logic [N-1:0]  pend_o,
  output logic          nmi_pend_o,
  output logic          irq_o,
  output logic          nmi_o
);
  localparam int EN_LO    = N;
  localparam int NMI_SEND = 2 * N;
  localparam int RST_EN   = 2 * N + 1;
  localparam int RST_GO   = 2 * N + 2;
  localparam int NMI_PB   = N;
  localparam int NMI_CLR  = N + 1;
  localparam int RST_PB   = N + 2;
  localparam int CW       = N + 2;

  logic          ctrl_wr, stat_wr;
  logic [N-1:0]  en_q, en_nxt, clr_db, wr_req, wr_en;
  logic          rsten_q, rsten_nxt;
  logic [CW-1:0] cell_set, cell_clr, cell_q, cell_nxt;
  logic [DW-1:0] ctrl_view, stat_view;
  logic          irq_q;

  assign ctrl_wr = wr_i && (reg_sel_e'(addr_i) == REG_CTRL);
  assign stat_wr = wr_i && (reg_sel_e'(addr_i) == REG_STAT);

  // doorbell n sits at the top of its group: reversed order
  for (genvar n = 0; n < N; n++) begin : g_map
    assign wr_req[n] = wdata_i[N-1-n];
    assign wr_en[n]  = wdata_i[EN_LO+N-1-n];
    assign clr_db[n] = stat_wr && wdata_i[N-1-n];
    assign ctrl_view[N-1-n]       = peer_pend_i[n];
    assign ctrl_view[EN_LO+N-1-n] = en_q[n];
    assign stat_view[N-1-n]       = cell_q[n];
  end

  assign ctrl_view[NMI_SEND]   = peer_nmi_i;
  assign ctrl_view[RST_EN]     = rsten_q;
  assign ctrl_view[DW-1:RST_GO] = '0;
  assign stat_view[NMI_PB]     = cell_q[N];
  assign stat_view[NMI_CLR]    = 1'b0;
  assign stat_view[RST_PB]     = cell_q[N+1];
  assign stat_view[DW-1:RST_PB+1] = '0;

  assign out_ring_o  = ctrl_wr ? wr_req : '0;
  assign out_nmi_o   = ctrl_wr && wdata_i[NMI_SEND];
  assign out_rstgo_o = ctrl_wr && wdata_i[RST_GO];

  assign en_nxt    = ctrl_wr ? wr_en : en_q;
  assign rsten_nxt = ctrl_wr ? wdata_i[RST_EN] : rsten_q;

  assign cell_set = {in_rstgo_i && rsten_q, in_nmi_i, in_ring_i};
  assign cell_clr = {stat_wr && wdata_i[RST_PB], stat_wr && wdata_i[NMI_CLR], clr_db};

  dbl_pend_bit #(.W(CW)) u_pend (
    .clk   (clk),
    .rst   (rst),
    .set_i (cell_set),
    .clr_i (cell_clr),
    .q_o   (cell_q),
    .nxt_o (cell_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rsten_q <= 1'b0;
      irq_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      en_q    <= en_nxt;
      rsten_q <= rsten_nxt;
      irq_q   <= (|(cell_nxt[N-1:0] & en_nxt)) || cell_nxt[N+1];
      rdata_o <= (reg_sel_e'(addr_i) == REG_STAT) ? stat_view : ctrl_view;
    end
  end

  assign pend_o     = cell_q[N-1:0];
  assign nmi_pend_o = cell_q[N];
  assign nmi_o      = cell_q[N];
  assign irq_o      = irq_q;

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == ((|(pend_o & en_q)) || cell_q[N+1]));
  // R8
  notice_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!rsten_q && !cell_q[N+1]) |=> !cell_q[N+1]);
  // R7
  nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nmi_o && !(stat_wr && wdata_i[NMI_CLR])) |=> nmi_o);
endmodule

// File: rtl/dbl_xside.sv
module dbl_xside #(
  parameter int N  = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_wr,
  input  logic          a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  output logic          a_nmi,
  input  logic          b_wr,
  input  logic          b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq,
  output logic          b_nmi
);
  logic [N-1:0] a_ring, b_ring, a_pend, b_pend;
  logic         a_nmis, b_nmis, a_go, b_go, a_nmip, b_nmip;

  dbl_side #(.N(N), .DW(DW)) u_a (
    .clk(clk), .rst(rst), .wr_i(a_wr), .addr_i(a_addr), .wdata_i(a_wdata),
    .rdata_o(a_rdata), .in_ring_i(b_ring), .in_nmi_i(b_nmis), .in_rstgo_i(b_go),
    .peer_pend_i(b_pend), .peer_nmi_i(b_nmip), .out_ring_o(a_ring),
    .out_nmi_o(a_nmis), .out_rstgo_o(a_go), .pend_o(a_pend),
    .nmi_pend_o(a_nmip), .irq_o(a_irq), .nmi_o(a_nmi)
  );

  dbl_side #(.N(N), .DW(DW)) u_b (
    .clk(clk), .rst(rst), .wr_i(b_wr), .addr_i(b_addr), .wdata_i(b_wdata),
    .rdata_o(b_rdata), .in_ring_i(a_ring), .in_nmi_i(a_nmis), .in_rstgo_i(a_go),
    .peer_pend_i(a_pend), .peer_nmi_i(a_nmip), .out_ring_o(b_ring),
    .out_nmi_o(b_nmis), .out_rstgo_o(b_go), .pend_o(b_pend),
    .nmi_pend_o(b_nmip), .irq_o(b_irq), .nmi_o(b_nmi)
  );

  // R3
  req_view_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_wr && a_addr == 1'b0) |=> (a_rdata[N-1:0] == {<<{$past(b_pend)}}));
endmodule

// File: tb/dbl_xside_bench.sv
module dbl_xside_bench;
  localparam int DW = 16;

  logic clk = 0, rst = 1;
  logic a_wr = 0, a_addr = 0, b_wr = 0, b_addr = 0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq, a_nmi, b_irq, b_nmi;

  always #5 clk = ~clk;

  dbl_xside u_dbl_xside (
    .clk(clk), .rst(rst),
    .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_irq(a_irq), .a_nmi(a_nmi),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_irq(b_irq), .b_nmi(b_nmi)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";
  // behavioural model, indexed 0 = A, 1 = B; doorbell n is bit n
  int m_pend[2], m_en[2], m_nmi[2], m_rsten[2], m_rstp[2], m_rd[2];

  function automatic int rev4(int x);
    return ((x & 1) << 3) | ((x & 2) << 1) | ((x & 4) >> 1) | ((x & 8) >> 3);
  endfunction
  function automatic int ctrl_val(int s);
    return rev4(m_pend[1-s]) | (rev4(m_en[s]) << 4) | (m_nmi[1-s] << 8) | (m_rsten[s] << 9);
  endfunction
  function automatic int stat_val(int s);
    return rev4(m_pend[s]) | (m_nmi[s] << 4) | (m_rstp[s] << 6);
  endfunction

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_step(int w[2], int ad[2], int wd[2]);
    int np[2], nn[2], nr[2], ne[2], nre[2];
    for (int s = 0; s < 2; s++) begin
      int p = 1 - s;
      int set_db = (w[p] && ad[p] == 0) ? rev4(wd[p] & 15) : 0;
      int clr_db = (w[s] && ad[s] == 1) ? rev4(wd[s] & 15) : 0;
      int set_n  = (w[p] && ad[p] == 0) ? (wd[p] >> 8) & 1 : 0;
      int clr_n  = (w[s] && ad[s] == 1) ? (wd[s] >> 5) & 1 : 0;
      int set_r  = (w[p] && ad[p] == 0) ? ((wd[p] >> 10) & 1) & m_rsten[s] : 0;
      int clr_r  = (w[s] && ad[s] == 1) ? (wd[s] >> 6) & 1 : 0;
      m_rd[s] = (ad[s] == 1) ? stat_val(s) : ctrl_val(s);
      np[s] = (m_pend[s] & ~clr_db) | (set_db & ~m_pend[s]);
      nn[s] = (m_nmi[s] & ~clr_n) | (set_n & ~m_nmi[s]);
      nr[s] = (m_rstp[s] & ~clr_r) | (set_r & ~m_rstp[s]);
      ne[s]  = (w[s] && ad[s] == 0) ? rev4((wd[s] >> 4) & 15) : m_en[s];
      nre[s] = (w[s] && ad[s] == 0) ? (wd[s] >> 9) & 1 : m_rsten[s];
    end
    for (int s = 0; s < 2; s++) begin
      m_pend[s] = np[s]; m_nmi[s] = nn[s]; m_rstp[s] = nr[s];
      m_en[s] = ne[s]; m_rsten[s] = nre[s];
    end
  endtask

  task automatic compare_all();
    chk("a_rdata (R9)", int'(a_rdata), m_rd[0]);
    chk("b_rdata (R9)", int'(b_rdata), m_rd[1]);
    chk("a_irq (R6)", int'(a_irq), ((m_pend[0] & m_en[0]) != 0 || m_rstp[0] != 0) ? 1 : 0);
    chk("b_irq (R6)", int'(b_irq), ((m_pend[1] & m_en[1]) != 0 || m_rstp[1] != 0) ? 1 : 0);
    chk("a_nmi (R7)", int'(a_nmi), m_nmi[0]);
    chk("b_nmi (R7)", int'(b_nmi), m_nmi[1]);
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(int aw, int aa, int ad, int bw, int ba, int bd);
    int w[2], a[2], d[2];
    w = '{aw, bw}; a = '{aa, ba}; d = '{ad, bd};
    a_wr = aw[0]; a_addr = aa[0]; a_wdata = ad[DW-1:0];
    b_wr = bw[0]; b_addr = ba[0]; b_wdata = bd[DW-1:0];
    @(posedge clk);
    model_step(w, a, d);
    @(negedge clk);
    compare_all();
  endtask

  task automatic rd(int aa, int ba);
    cyc(0, aa, 0, 0, ba, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      m_pend[s] = 0; m_en[s] = 0; m_nmi[s] = 0; m_rsten[s] = 0; m_rstp[s] = 0; m_rd[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    compare_all();
    rd(0, 1); rd(1, 0);

    cur_req = "R2";
    cyc(1, 0, 16'h0008, 0, 1, 0);       // A rings doorbell 0
    rd(0, 1);
    cyc(1, 0, 16'h0000, 0, 1, 0);       // zeros do not cancel
    rd(0, 1);
    chk("b status db0 (R2)", int'(b_rdata[3]), 1);

    cur_req = "R3";
    rd(0, 0);
    chk("a ctrl req db0 (R3)", int'(a_rdata[3]), 1);

    cur_req = "R4";
    cyc(0, 0, 0, 1, 1, 16'h0000);       // W1C of zero: nothing
    rd(0, 1);
    cyc(0, 0, 0, 1, 1, 16'h0008);       // B acks doorbell 0
    rd(0, 1);
    chk("b status after ack (R4)", int'(b_rdata[3]), 0);
    cur_req = "R3";
    chk("a ctrl req after ack (R3)", int'(a_rdata[3]), 0);

    cur_req = "R5";
    cyc(1, 0, 16'h0004, 0, 1, 0);       // ring db1
    cyc(1, 0, 16'h0004, 0, 1, 0);       // ring again: no effect
    cyc(1, 0, 16'h0004, 1, 1, 16'h0004); // collide on set bit -> cleared
    rd(0, 1);
    chk("db1 after collision (R5)", int'(b_rdata[2]), 0);
    cyc(1, 0, 16'h0002, 1, 1, 16'h0002); // collide on clear bit -> set
    rd(0, 1);
    chk("db2 after collision (R5)", int'(b_rdata[1]), 1);

    cur_req = "R6";
    cyc(0, 0, 0, 1, 0, 16'h0020);       // B enables db2
    chk("b_irq enabled (R6)", int'(b_irq), 1);
    cyc(0, 0, 0, 1, 0, 16'h0000);
    chk("b_irq disabled (R6)", int'(b_irq), 0);
    cyc(0, 0, 0, 1, 1, 16'h0002);

    cur_req = "R7";
    cyc(1, 0, 16'h0100, 0, 0, 0);       // A sends NMI
    chk("b_nmi set (R7)", int'(b_nmi), 1);
    cyc(0, 0, 0, 1, 1, 16'h0010);       // writing pending position: no effect
    chk("b_nmi kept (R7)", int'(b_nmi), 1);
    rd(0, 0);
    cyc(0, 0, 0, 1, 1, 16'h0020);       // dedicated clear
    chk("b_nmi cleared (R7)", int'(b_nmi), 0);

    cur_req = "R8";
    cyc(1, 0, 16'h0400, 0, 1, 0);       // notice with enable off
    rd(0, 1);
    chk("notice gated (R8)", int'(b_rdata[6]), 0);
    cyc(0, 0, 0, 1, 0, 16'h0200);       // B enables notice
    cyc(1, 0, 16'h0400, 0, 1, 0);
    chk("notice irq (R8)", int'(b_irq), 1);
    cyc(0, 0, 0, 1, 1, 16'h0040);
    chk("notice cleared (R8)", int'(b_irq), 0);

    cur_req = "R9";
    for (int i = 0; i < 400; i++) begin
      int r0 = $urandom, r1 = $urandom;
      cyc(r0 & 1, (r0 >> 1) & 1, (r0 >> 8) & 16'h07ff, r1 & 1, (r1 >> 1) & 1, (r1 >> 8) & 16'h07ff);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule